// File: doc/BRIEF.md
# Synchronizable Even Clock Divider Bank

This block produces several clock outputs from one fast input clock. Each output channel has its own 8-bit divide code, a 2-bit mode select and an enable. A channel in a dividing mode emits the input clock divided by twice its code, with a 50% duty cycle. A channel in a pass mode forwards the input clock unchanged. All configuration arrives on parallel ports.

An active-low sync input clears every divider at once, so all divided outputs restart together and share rising edges. Two shared gates override the per-channel enables: a global enable bit and an output-enable pin. A disabled channel drives low, but its divider keeps running. When the channel is enabled again, it comes back in phase with the others.

Top module: `clk_div_bank`

## Requirements
- R1: In a dividing mode with code N (1..255), the channel output is high for N input cycles and then low for N input cycles, giving a period of 2*N cycles.
- R2: Code 0 divides exactly as code 1 does (period 2). code_err[i] is 1 exactly while channel i's code is 0.
- R3: Mode encoding per channel: 2'b01 (divided) and 2'b11 (divided and delayed) use the divider. 2'b00 (bypass) and 2'b10 (delayed, which has no delay here) pass clk_in straight through.
- R4: While sync_n is low, every divider output is held low. On the first rising clk_in edge that samples sync_n high, every divided output rises together.
- R5: clk_out[i] is 0 unless ch_en[i], global_en and oe_pin are all 1.
- R6: A channel that is disabled by any gate keeps counting. After it is re-enabled, its output matches a channel that was never disabled.
- R7: A code change takes effect only at the divider's next output toggle. The half-period already in progress keeps its old length.
- R8: While rst_n is low, divider outputs are low. After release, the first clock edge raises every divided output, as a sync release does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Active-low divider sync (synchronous clear) |
| global_en | input | 1 | Global output enable bit |
| oe_pin | input | 1 | Output-enable pin, active high |
| div_code | input | NUM_CH*CODE_W | Divide codes, channel i at bits [i*CODE_W +: CODE_W] |
| mode_sel | input | 2*NUM_CH | Mode per channel, channel i at bits [2*i +: 2] |
| ch_en | input | NUM_CH | Per-channel enable |
| clk_out | output | NUM_CH | Channel clock outputs |
| code_err | output | NUM_CH | Per-channel flag that the code is 0 |

## Verification
The bench builds the block with its default parameters: four channels and 8-bit codes. These values bring the largest code (255, a 510-cycle period) within reach in about a thousand cycles. With four channels, one run can hold codes 1, 3, 0 and 5 side by side, so alignment across unequal ratios is checked on every sync release. Expected levels come from a closed-form phase formula for each cycle after release, with gate windows overlaid. A separate case checks a code change part-way through a half-period.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic [1:0] {
    MODE_PASS    = 2'b00,
    MODE_DIV     = 2'b01,
    MODE_DLY     = 2'b10,
    MODE_DIV_DLY = 2'b11
  } out_mode_e;

  // Dividing modes; the delayed-only mode behaves as pass here
  function automatic logic uses_divider(input out_mode_e m);
    return (m == MODE_DIV) || (m == MODE_DIV_DLY);
  endfunction

endpackage

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic [CODE_W-1:0] code,
  output logic              phase,
  output logic              tick,
  output logic              code_bad
);

  // Code zero is replaced by one
  function automatic logic [CODE_W-1:0] eff_code(input logic [CODE_W-1:0] c);
    return (c == '0) ? CODE_W'(1) : c;
  endfunction

  logic [CODE_W-1:0] cnt;

  assign code_bad = (code == '0);
  assign tick     = sync_n && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!sync_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (cnt == '0) begin
      phase <= ~phase;
      cnt   <= eff_code(code) - CODE_W'(1);
    end else begin
      cnt <= cnt - CODE_W'(1);
    end
  end

endmodule

// File: rtl/clkdiv_outsel.sv
module clkdiv_outsel
  import clkdiv_pkg::*;
(
  input  logic      clk_in,
  input  logic      phase,
  input  out_mode_e mode,
  input  logic      en_ch,
  input  logic      en_shared,
  output logic      out
);

  always_comb begin
    if (!(en_ch && en_shared))
      out = 1'b0;
    else if (uses_divider(mode))
      out = phase;
    else
      out = clk_in;
  end

endmodule

// File: rtl/clk_div_bank.sv
module clk_div_bank
  import clkdiv_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 8
) (
  input  logic                     clk_in,
  input  logic                     rst_n,
  input  logic                     sync_n,
  input  logic                     global_en,
  input  logic                     oe_pin,
  input  logic [NUM_CH*CODE_W-1:0] div_code,
  input  logic [2*NUM_CH-1:0]      mode_sel,
  input  logic [NUM_CH-1:0]        ch_en,
  output logic [NUM_CH-1:0]        clk_out,
  output logic [NUM_CH-1:0]        code_err
);

  localparam int CODE_BUS_W = NUM_CH * CODE_W;

  logic              en_shared;
  logic [NUM_CH-1:0] div_phase;
  logic [NUM_CH-1:0] div_tick;

  assign en_shared = global_en & oe_pin;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [CODE_W-1:0] code_i;
    out_mode_e         mode_i;

    assign code_i = div_code[i*CODE_W +: CODE_W];
    assign mode_i = out_mode_e'(mode_sel[2*i +: 2]);

    clkdiv_counter #(.CODE_W(CODE_W)) u_cnt (
      .clk      (clk_in),
      .rst_n    (rst_n),
      .sync_n   (sync_n),
      .code     (code_i),
      .phase    (div_phase[i]),
      .tick     (div_tick[i]),
      .code_bad (code_err[i])
    );

    clkdiv_outsel u_sel (
      .clk_in    (clk_in),
      .phase     (div_phase[i]),
      .mode      (mode_i),
      .en_ch     (ch_en[i]),
      .en_shared (en_shared),
      .out       (clk_out[i])
    );
  end

  if (CODE_BUS_W < NUM_CH) begin : g_bad_param
    initial $error("CODE_W must be at least 1");
  end

endmodule

// File: rtl/clk_div_bank_chk.sv
module clk_div_bank_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk_in,
  input logic              rst_n,
  input logic              sync_n,
  input logic              global_en,
  input logic              oe_pin,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] clk_out,
  input logic [NUM_CH-1:0] div_phase,
  input logic [NUM_CH-1:0] div_tick
);

  logic sync_q;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) sync_q <= 1'b1;
    else        sync_q <= sync_n;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    a_r4_sync_clears: assert property (@(posedge clk_in) disable iff (!rst_n)
      !sync_n |=> !div_phase[i]);

    a_r4_first_rise: assert property (@(posedge clk_in) disable iff (!rst_n)
      (sync_n && !sync_q) |=> div_phase[i]);

    a_r1_hold_between_ticks: assert property (@(posedge clk_in) disable iff (!rst_n)
      (sync_n && !div_tick[i]) |=> $stable(div_phase[i]));

    a_r1_toggle_on_tick: assert property (@(posedge clk_in) disable iff (!rst_n)
      div_tick[i] |=> (div_phase[i] != $past(div_phase[i])));

    a_r5_gated_low: assert property (@(posedge clk_in) disable iff (!rst_n)
      !(ch_en[i] && global_en && oe_pin) |-> !clk_out[i]);
  end

endmodule

bind clk_div_bank clk_div_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_in    (clk_in),
  .rst_n     (rst_n),
  .sync_n    (sync_n),
  .global_en (global_en),
  .oe_pin    (oe_pin),
  .ch_en     (ch_en),
  .clk_out   (clk_out),
  .div_phase (div_phase),
  .div_tick  (div_tick)
);

// File: tb/clk_div_bank_test.sv
`timescale 1ns/1ps
module clk_div_bank_test;

  localparam int NCH = 4;
  localparam int CW  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sync_n = 1'b1;
  logic            global_en = 1'b1;
  logic            oe_pin = 1'b1;
  logic [NCH*CW-1:0] div_code;
  logic [2*NCH-1:0]  mode_sel;
  logic [NCH-1:0]    ch_en;
  logic [NCH-1:0]    clk_out;
  logic [NCH-1:0]    code_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct { logic [NCH-1:0] v; string tag; } exp_t;
  exp_t sbq[$];

  always #2 clk = ~clk;

  clk_div_bank uut (
    .clk_in(clk), .rst_n(rst_n), .sync_n(sync_n), .global_en(global_en),
    .oe_pin(oe_pin), .div_code(div_code), .mode_sel(mode_sel), .ch_en(ch_en),
    .clk_out(clk_out), .code_err(code_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops one expected vector per falling edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      check(clk_out === e.v, e.tag, 32'(clk_out), 32'(e.v));
    end
  end

  task automatic set_code(input int ch, input int val);
    div_code[ch*CW +: CW] = CW'(val);
  endtask

  task automatic set_mode(input int ch, input logic [1:0] m);
    mode_sel[2*ch +: 2] = m;
  endtask

  task automatic drain();
    while (sbq.size() > 0) @(negedge clk);
    #1;
  endtask

  // Hold sync low a few cycles, check divided outputs are low, release
  task automatic sync_pulse();
    @(posedge clk); #1 sync_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < NCH; i++)
      if (mode_sel[2*i] && ch_en[i])
        check(clk_out[i] === 1'b0, "R4 sync hold", 32'(clk_out[i]), 0);
    sync_n = 1'b1;
  endtask

  // Driver: cycle j after release; pushes expected levels from the phase formula
  task automatic stream(input int n, input int nv[NCH], input int ga, input int gb,
                        input int oa, input int ob, input string tag);
    for (int j = 0; j < n; j++) begin
      logic [NCH-1:0] ev;
      exp_t e;
      @(posedge clk); #1;
      global_en = !(j >= ga && j < gb);
      oe_pin    = !(j >= oa && j < ob);
      for (int i = 0; i < NCH; i++) begin
        bit hi;
        hi = ((j % (2*nv[i])) < nv[i]);
        ev[i] = mode_sel[2*i] && hi && ch_en[i] && global_en && oe_pin;
      end
      e.v = ev; e.tag = tag;
      sbq.push_back(e);
    end
    drain();
    global_en = 1'b1; oe_pin = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin set_code(i, 1); set_mode(i, 2'b01); end
    ch_en = '1;

    // R8: reset holds outputs low
    repeat (3) @(posedge clk);
    #1 check(clk_out === '0, "R8 reset low", 32'(clk_out), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    stream(12, '{1, 1, 1, 1}, -1, -1, -1, -1, "R8 post-reset");

    // R1 R2 R4: mixed codes including zero, all rise together
    set_code(0, 1); set_code(1, 3); set_code(2, 0); set_code(3, 5);
    #1 check(code_err === 4'b0100, "R2 code_err", 32'(code_err), 32'h4);
    sync_pulse();
    stream(60, '{1, 3, 1, 5}, -1, -1, -1, -1, "R1 R2 R4 mixed");

    // R3: divided-and-delayed mode divides too
    set_mode(1, 2'b11); set_mode(3, 2'b11);
    sync_pulse();
    stream(40, '{1, 3, 1, 5}, -1, -1, -1, -1, "R3 div+dly");

    // R5 R6: gate windows and a disabled channel; phase kept
    ch_en = 4'b1011;
    sync_pulse();
    stream(60, '{1, 3, 1, 5}, 10, 25, 33, 47, "R5 R6 gating");
    ch_en = '1;

    // R1 boundary: largest code
    set_code(3, 255); set_code(1, 2);
    sync_pulse();
    stream(1100, '{1, 2, 1, 255}, -1, -1, -1, -1, "R1 code 255");

    // R7: change code mid half-period on channel 0 only
    ch_en = 4'b0001; set_code(0, 3);
    sync_pulse();
    for (int j = 0; j < 30; j++) begin
      exp_t e;
      @(posedge clk); #1;
      if (j == 1) set_code(0, 5);
      e.v = (j < 3) ? 4'b0001 : ((((j - 3) % 10) < 5) ? 4'b0000 : 4'b0001);
      e.tag = "R7 code change";
      sbq.push_back(e);
    end
    drain();

    // R3 R5: bypass and delayed-only modes forward clk_in
    ch_en = '1;
    set_mode(0, 2'b00); set_mode(1, 2'b10);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      check(clk_out[1:0] === 2'b11, "R3 pass high", 32'(clk_out[1:0]), 3);
      @(negedge clk); #1;
      check(clk_out[1:0] === 2'b00, "R3 pass low", 32'(clk_out[1:0]), 0);
    end
    @(negedge clk); #1 global_en = 1'b0;
    @(posedge clk); #1;
    check(clk_out === '0, "R5 global off", 32'(clk_out), 0);
    global_en = 1'b1; oe_pin = 1'b0;
    @(posedge clk); #1;
    check(clk_out === '0, "R5 pin low", 32'(clk_out), 0);
    oe_pin = 1'b1;
    @(posedge clk); #1;
    check(clk_out[1:0] === 2'b11, "R5 restored", 32'(clk_out[1:0]), 3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule